// File: doc/BRIEF.md
# Program-Cycle Status Poll Responder

This block decides what a host sees on a 32-bit read bus while a non-volatile array is busy with an internal program cycle. While the busy flag is high, each 8-bit lane returns two status bits instead of stored data. Bit 7 of the lane is the complement of bit 7 of the byte last loaded into that lane. Bit 6 of the lane is a toggle bit that changes on every accepted read. Software polls one fixed address until bit 7 matches what it wrote, or until bit 6 stops changing between two reads.

When the busy flag drops, reads pass the array read data through unchanged. A protect input held low blocks all reads: the strobe is ignored and the bus is not driven. Each accepted read produces a registered result that is driven for one cycle, one clock after the strobe. The program engine and the array are outside the block. The responder only chooses and formats the returned word.

Top module: `poll_status_responder`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `rd_drive` is low.
- R2: A read is accepted when `rd_stb` is high and `prot_n` is high at a clock edge. `rd_drive` is high for exactly the following cycle, and `rd_data` carries the result in that cycle.
- R3: A strobe given while `prot_n` is low is ignored. `rd_drive` stays low and the toggle bit does not advance.
- R4: For a read accepted while `busy` is high, bit 7 of each lane (bits 7, 15, 23 and 31) equals the inverse of bit 7 of the matching byte of `last_load`.
- R5: While busy, bit 6 of every lane (bits 6, 14, 22 and 30) reads 1 on the first accepted read of a program cycle and alternates on each further accepted read.
- R6: While busy, all bits of each lane other than bits 6 and 7 read 0.
- R7: For a read accepted while `busy` is low, `rd_data` equals `array_rdata` as sampled at the accepting edge.
- R8: Each rising edge of `busy` re-arms the toggle, so the first read of a new cycle returns 1 in bit 6 regardless of the previous cycle's final value.
- R9: The toggle bit advances only on accepted reads, never with elapsed cycles alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | One-cycle read request |
| prot_n | input | 1 | Read permission; low blocks all reads |
| busy | input | 1 | Internal program cycle in progress |
| last_load | input | 32 | Last data word loaded by the host |
| array_rdata | input | 32 | Stored data from the array at the read address |
| rd_data | output | 32 | Returned read word, valid while `rd_drive` is high |
| rd_drive | output | 1 | Read bus is driven this cycle |

## Verification
The assertions assume three things about the inputs. `busy` and `last_load` stay steady across a read's accepting edge. `busy` only rises after the engine has captured the loaded data. `prot_n` is a level and not a glitch. The stimulus changes inputs only on falling clock edges. It sets `last_load` in the same cycle that `busy` rises and holds it for the whole cycle. It also holds `array_rdata` fixed at the polled location while reads are in flight. Protected reads are issued only with `prot_n` already low for the full strobe cycle.

// File: rtl/poll_pkg.sv
package poll_pkg;
  parameter int unsigned DEF_LANES  = 4;
  parameter int unsigned DEF_LANE_W = 8;
  parameter int unsigned POLL_POS   = 7;
  parameter int unsigned TOG_POS    = 6;
endpackage

// File: rtl/poll_toggle.sv
module poll_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic rd_acc,
  output logic tog_now
);
  logic busy_q, tog_q;
  logic busy_rise, tog_cur, tog_d, tog_en;

  always_comb begin
    busy_rise = busy & ~busy_q;
    tog_cur   = busy_rise ? 1'b1 : tog_q;
    tog_en    = busy_rise | (busy & rd_acc);
    tog_d     = (busy & rd_acc) ? ~tog_cur : tog_cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tog_q  <= 1'b1;
    end else begin
      busy_q <= busy;
      if (tog_en) tog_q <= tog_d;
    end
  end

  assign tog_now = tog_cur;

  // R8: a new cycle without a read leaves the toggle armed at 1
  assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !rd_acc) |=> tog_q);

  // R9: no accepted read inside a cycle keeps the toggle steady
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_q && !rd_acc) |=> (tog_q == $past(tog_q)));
endmodule

// File: rtl/poll_lane.sv
module poll_lane #(
  parameter int unsigned LANE_W   = poll_pkg::DEF_LANE_W,
  parameter int unsigned POLL_POS = poll_pkg::POLL_POS,
  parameter int unsigned TOG_POS  = poll_pkg::TOG_POS
) (
  input  logic              busy,
  input  logic              tog,
  input  logic [LANE_W-1:0] load_byte,
  input  logic [LANE_W-1:0] array_byte,
  output logic [LANE_W-1:0] out_byte
);
  logic [LANE_W-1:0] status;
  logic              unused_load;

  always_comb begin
    status           = '0;
    status[POLL_POS] = ~load_byte[POLL_POS];
    status[TOG_POS]  = tog;
    out_byte         = busy ? status : array_byte;
  end

  assign unused_load = ^load_byte;
endmodule

// File: rtl/poll_status_responder.sv
module poll_status_responder #(
  parameter int unsigned LANES  = poll_pkg::DEF_LANES,
  parameter int unsigned LANE_W = poll_pkg::DEF_LANE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_stb,
  input  logic                    prot_n,
  input  logic                    busy,
  input  logic [LANES*LANE_W-1:0] last_load,
  input  logic [LANES*LANE_W-1:0] array_rdata,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_drive
);
  localparam int unsigned BUS_W = LANES * LANE_W;

  logic             rd_acc;
  logic             tog_now;
  logic [BUS_W-1:0] word_d;
  logic [BUS_W-1:0] data_q;
  logic             drive_q;

  assign rd_acc = rd_stb & prot_n;

  poll_toggle u_toggle (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .rd_acc (rd_acc),
    .tog_now(tog_now)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    poll_lane #(.LANE_W(LANE_W)) u_lane (
      .busy      (busy),
      .tog       (tog_now),
      .load_byte (last_load[g*LANE_W +: LANE_W]),
      .array_byte(array_rdata[g*LANE_W +: LANE_W]),
      .out_byte  (word_d[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      data_q  <= '0;
    end else begin
      drive_q <= rd_acc;
      if (rd_acc) data_q <= word_d;
    end
  end

  assign rd_data  = data_q;
  assign rd_drive = drive_q;

  // R2: the bus is driven only after an accepted strobe
  assert_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive |-> $past(rd_stb && prot_n));

  // R3: protect low blocks the next cycle's drive
  assert_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_n |=> !rd_drive);

  // R7: an idle read passes stored data through
  assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_drive && !$past(busy)) |-> (rd_data == $past(array_rdata)));

  for (genvar a = 0; a < LANES; a++) begin : g_chk
    // R4: a busy read shows the inverted top bit of the loaded byte
    assert_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_drive && $past(busy)) |->
        (rd_data[a*LANE_W + poll_pkg::POLL_POS] == !$past(last_load[a*LANE_W + poll_pkg::POLL_POS])));
    // R6: the low status bits of a busy lane read zero
    assert_rest_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_drive && $past(busy)) |-> (rd_data[a*LANE_W +: 6] == 6'd0));
  end
endmodule

// File: tb/poll_status_responder_test.sv
module poll_status_responder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_stb, prot_n, busy;
  logic [31:0] last_load, array_rdata;
  logic [31:0] rd_data;
  logic        rd_drive;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  bit    tb_tog = 1'b1;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_seen;

  always #5 clk = ~clk;

  poll_status_responder uut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .prot_n(prot_n), .busy(busy),
    .last_load(last_load), .array_rdata(array_rdata),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic bz, input logic tg, input logic [31:0] ld, input logic [31:0] arr);
    logic [31:0] w;
    if (!bz) return arr;
    w = '0;
    for (int i = 0; i < 4; i++) begin
      w[i*8+7] = ~ld[i*8+7];
      w[i*8+6] = tg;
    end
    return w;
  endfunction

  // monitor: pops expected words whenever the bus is driven
  always @(negedge clk) begin
    if (rst_n && rd_drive) begin
      last_seen = rd_data;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected drive", {31'd0, rd_drive}, 32'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e, t, rd_data, e);
      end
    end
  end

  task automatic do_read(input string tag);
    rd_stb = 1'b1;
    if (prot_n) begin
      exp_q.push_back(model(busy, tb_tog, last_load, array_rdata));
      tag_q.push_back(tag);
      if (busy) tb_tog = ~tb_tog;
    end
    @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic start_cycle(input logic [31:0] w);
    last_load = w;
    busy = 1'b1;
    tb_tog = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_stb = 1'b0; prot_n = 1'b1; busy = 1'b0;
    last_load = '0; array_rdata = '0; last_seen = '0;
    repeat (3) @(negedge clk);
    check(rd_drive == 1'b0, "R1 drive in reset", {31'd0, rd_drive}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_drive == 1'b0, "R1 drive after release", {31'd0, rd_drive}, 32'd0);

    // R7 / R2: idle reads pass array data
    array_rdata = 32'h1234_5678; do_read("R7 idle pass a");
    array_rdata = 32'hFFFF_0000; do_read("R7 idle pass b");
    array_rdata = 32'h80C0_40FF; do_read("R2 idle read");

    // R4 R5 R6: busy reads
    start_cycle(32'h8000_FF7F);
    array_rdata = 32'hDEAD_BEEF;
    do_read("R5 first toggle R4 R6");
    do_read("R5 second toggle");
    do_read("R5 third toggle");
    // R9: idle time alone does not advance the toggle
    repeat (7) @(negedge clk);
    do_read("R9 no time advance");
    // R3: protected read ignored, no drive, toggle unchanged
    prot_n = 1'b0;
    @(negedge clk);
    do_read("R3 ignored");
    check(rd_drive == 1'b0, "R3 no drive", {31'd0, rd_drive}, 32'd0);
    check(exp_q.size() == 0, "R3 queue", exp_q.size(), 0);
    prot_n = 1'b1;
    @(negedge clk);
    do_read("R3 toggle kept");
    do_read("R4 busy poll");
    // cycle ends; tb_tog now 0 after odd count? ensure state is 0
    if (tb_tog) do_read("R5 extra");
    busy = 1'b0;
    array_rdata = 32'h8000_FF7F;
    @(negedge clk);
    do_read("R7 after completion");

    // R8: new cycle re-arms toggle to 1
    start_cycle(32'h0080_0080);
    do_read("R8 rearm first read");
    do_read("R8 second read");
    busy = 1'b0;
    @(negedge clk);

    // host polling loop
    begin
      logic [31:0] word;
      int inv_polls;
      bit  matched;
      word = 32'hA5C3_1E87;
      inv_polls = 0;
      matched = 0;
      array_rdata = 32'h0;
      start_cycle(word);
      for (int i = 0; i < 20 && !matched; i++) begin
        if (i == 5) begin
          busy = 1'b0;
          array_rdata = word;
          @(negedge clk);
        end
        do_read("R4 poll loop");
        if ({last_seen[31], last_seen[23], last_seen[15], last_seen[7]} ==
            {word[31], word[23], word[15], word[7]}) matched = 1;
        else inv_polls++;
      end
      check(inv_polls == 5, "R4 inverted poll count", inv_polls, 5);
      check(last_seen == word, "R7 final true data", last_seen, word);
    end

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule